// File: doc/BRIEF.md
# Socket Posted-Write Buffer with Flush Control

This block buffers host write cycles headed for one card socket so the host can move on before the slower card-side cycle completes. Each buffered entry carries an address, a 16-bit data word and byte enables. The host side pushes entries until the buffer is full, and the card side pops them oldest first. The card side sees the oldest entry at its outputs whenever one is present, without waiting a cycle after the pop.

A byte-wide control and status register sits at a fixed index of the socket register space. Its top bit reads back whether the buffer is empty. Writing that bit with one throws away everything buffered. The low seven bits are plain storage for software and have no other effect.

The buffer also empties itself, with no software action, when any of three conditions holds: system power is not good, the card is not present, or the socket supply enable is off. Every flush takes effect at the clock edge where its cause is seen. A host push in that same cycle is lost.

Top module: `pw_fifo_socket`

## Requirements
- R1: After reset, a read at index 0x17 returns 0x80, `host_full` is 0 and `card_valid` is 0.
- R2: Entries leave in the order they were pushed, with address, data and byte enables unchanged. While the buffer holds data, `card_valid` is 1 and the `card_*` outputs show the oldest entry.
- R3: The buffer holds 8 entries. `host_full` is 1 exactly when 8 are held, and a push while full is discarded.
- R4: A pop while the buffer is empty has no effect.
- R5: A read at index 0x17 returns the empty flag in bit 7 (1 = empty, 0 = holds data) and the scratch bits in bits 6:0. A read at any other index returns 0x00.
- R6: A write to index 0x17 with bit 7 set empties the buffer at that clock edge.
- R7: A write to index 0x17 stores bits 6:0 as scratch bits that read back unchanged. When bit 7 of that write is 0, the buffered entries are kept.
- R8: While `power_good` is 0, the buffer is emptied at every edge and stays empty.
- R9: While `card_present` is 0, the buffer is emptied at every edge.
- R10: While `supply_en` is 0, the buffer is emptied at every edge.
- R11: A push in the same cycle as any flush cause is dropped, so the buffer is empty after that edge.
- R12: A write to any index other than 0x17 leaves both the scratch bits and the buffer contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_push | input | 1 | Host requests to buffer one write |
| host_addr | input | 12 | Address of the pushed write |
| host_data | input | 16 | Data of the pushed write |
| host_be | input | 2 | Byte enables of the pushed write |
| host_full | output | 1 | Buffer holds 8 entries; host must stall |
| card_pop | input | 1 | Card side consumes the oldest entry |
| card_valid | output | 1 | An entry is available to the card side |
| card_addr | output | 12 | Address of the oldest entry |
| card_data | output | 16 | Data of the oldest entry |
| card_be | output | 2 | Byte enables of the oldest entry |
| reg_index | input | 8 | Register index for reads and writes |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_index` |
| power_good | input | 1 | System power good; low flushes |
| card_present | input | 1 | Card detected; low flushes |
| supply_en | input | 1 | Socket supply enable; low flushes |

## Verification
A flush and a push can fall in the same cycle, and a flush can also coincide with a pop. Either way, the flush must win. The bench provokes this by holding `host_push` high across a cycle where a flush cause is also asserted: the register flush bit, power-good low, card removal or supply off. It does this both on a partly filled buffer and on a completely full one. The result is judged one edge later at the ports: `card_valid` must be 0, `host_full` must be 0, and the empty bit at index 0x17 must read 1.

// File: rtl/pw_fifo_pkg.sv
`timescale 1ns/1ps
package pw_fifo_pkg;
    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 16;
    localparam int BE_W      = DATA_W / 8;
    localparam int REG_W     = 8;
    localparam int IDX_W     = 8;
    localparam int FLUSH_BIT = REG_W - 1;
    localparam int SCRATCH_W = REG_W - 1;

    localparam int CAUSE_SW    = 0;
    localparam int CAUSE_PGOOD = 1;
    localparam int CAUSE_CARD  = 2;
    localparam int CAUSE_VCC   = 3;
    localparam int NUM_CAUSES  = 4;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
    } pw_entry_t;
endpackage

// File: rtl/pw_fifo_store.sv
`timescale 1ns/1ps
module pw_fifo_store
    import pw_fifo_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             push_i,
    input  pw_entry_t        push_entry_i,
    input  logic             pop_i,
    output pw_entry_t        head_o,
    output logic             full_o,
    output logic             empty_o,
    output logic [CNT_W-1:0] count_o
);
    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    pw_entry_t  slots [DEPTH];
    logic       push_ok, pop_ok, write_en;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d     = st_q;
        push_ok  = push_i && (st_q.count != CNT_W'(DEPTH));
        pop_ok   = pop_i && (st_q.count != '0);
        write_en = push_ok && !flush_i;
        if (flush_i) begin
            st_d = '0;
        end else begin
            if (push_ok) st_d.wr_ptr = ptr_inc(st_q.wr_ptr);
            if (pop_ok)  st_d.rd_ptr = ptr_inc(st_q.rd_ptr);
            unique case ({push_ok, pop_ok})
                2'b10:   st_d.count = st_q.count + 1'b1;
                2'b01:   st_d.count = st_q.count - 1'b1;
                default: st_d.count = st_q.count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (write_en) slots[st_q.wr_ptr] <= push_entry_i;
    end

    assign head_o  = slots[st_q.rd_ptr];
    assign full_o  = (st_q.count == CNT_W'(DEPTH));
    assign empty_o = (st_q.count == '0);
    assign count_o = st_q.count;
endmodule

// File: rtl/pw_flush_ctrl.sv
`timescale 1ns/1ps
module pw_flush_ctrl
    import pw_fifo_pkg::*;
(
    input  logic                  sw_flush_i,
    input  logic                  power_good_i,
    input  logic                  card_present_i,
    input  logic                  supply_en_i,
    output logic [NUM_CAUSES-1:0] cause_o,
    output logic                  flush_o
);
    always_comb begin
        cause_o              = '0;
        cause_o[CAUSE_SW]    = sw_flush_i;
        cause_o[CAUSE_PGOOD] = !power_good_i;
        cause_o[CAUSE_CARD]  = !card_present_i;
        cause_o[CAUSE_VCC]   = !supply_en_i;
    end

    assign flush_o = |cause_o;
endmodule

// File: rtl/pw_ctrl_reg.sv
`timescale 1ns/1ps
module pw_ctrl_reg
    import pw_fifo_pkg::*;
#(
    parameter logic [IDX_W-1:0] REG_INDEX = 8'h17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] index_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             fifo_empty_i,
    output logic [REG_W-1:0] rdata_o,
    output logic             flush_req_o
);
    typedef struct packed {
        logic [SCRATCH_W-1:0] scratch;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic       hit;

    always_comb begin
        hit         = (index_i == REG_INDEX);
        st_d        = st_q;
        flush_req_o = 1'b0;
        if (wr_en_i && hit) begin
            st_d.scratch = wdata_i[SCRATCH_W-1:0];
            flush_req_o  = wdata_i[FLUSH_BIT];
        end
        rdata_o = hit ? {fifo_empty_i, st_q.scratch} : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pw_fifo_socket.sv
`timescale 1ns/1ps
module pw_fifo_socket
    import pw_fifo_pkg::*;
#(
    parameter int                DEPTH     = 8,
    parameter logic [IDX_W-1:0]  REG_INDEX = 8'h17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_push,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_data,
    input  logic [BE_W-1:0]   host_be,
    output logic              host_full,
    input  logic              card_pop,
    output logic              card_valid,
    output logic [ADDR_W-1:0] card_addr,
    output logic [DATA_W-1:0] card_data,
    output logic [BE_W-1:0]   card_be,
    input  logic [IDX_W-1:0]  reg_index,
    input  logic              reg_wr_en,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              power_good,
    input  logic              card_present,
    input  logic              supply_en
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    pw_entry_t             push_entry, head;
    logic                  fifo_empty, sw_flush, flush;
    logic [NUM_CAUSES-1:0] flush_cause;
    logic [CNT_W-1:0]      occupancy;

    assign push_entry = '{addr: host_addr, data: host_data, be: host_be};

    pw_ctrl_reg #(.REG_INDEX(REG_INDEX)) u_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .index_i      (reg_index),
        .wr_en_i      (reg_wr_en),
        .wdata_i      (reg_wdata),
        .fifo_empty_i (fifo_empty),
        .rdata_o      (reg_rdata),
        .flush_req_o  (sw_flush)
    );

    pw_flush_ctrl u_flush (
        .sw_flush_i     (sw_flush),
        .power_good_i   (power_good),
        .card_present_i (card_present),
        .supply_en_i    (supply_en),
        .cause_o        (flush_cause),
        .flush_o        (flush)
    );

    pw_fifo_store #(.DEPTH(DEPTH)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush),
        .push_i       (host_push),
        .push_entry_i (push_entry),
        .pop_i        (card_pop),
        .head_o       (head),
        .full_o       (host_full),
        .empty_o      (fifo_empty),
        .count_o      (occupancy)
    );

    assign card_valid = !fifo_empty;
    assign card_addr  = head.addr;
    assign card_data  = head.data;
    assign card_be    = head.be;
endmodule

// File: rtl/pw_fifo_checker.sv
`timescale 1ns/1ps
module pw_fifo_checker
    import pw_fifo_pkg::*;
#(
    parameter int               DEPTH     = 8,
    parameter logic [IDX_W-1:0] REG_INDEX = 8'h17,
    localparam int              CNT_W     = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_push,
    input logic             host_full,
    input logic             card_pop,
    input logic             card_valid,
    input logic [IDX_W-1:0] reg_index,
    input logic             reg_wr_en,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             power_good,
    input logic             card_present,
    input logic             supply_en,
    input logic [CNT_W-1:0] occupancy
);
    logic sw_hit, any_flush;
    assign sw_hit    = reg_wr_en && (reg_index == REG_INDEX) && reg_wdata[FLUSH_BIT];
    assign any_flush = sw_hit || !power_good || !card_present || !supply_en;

    assert_occupancy_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= CNT_W'(DEPTH));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        host_full && host_push && !card_pop && !any_flush |=> host_full);

    assert_full_has_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        host_full |-> card_valid);

    assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        card_pop && !card_valid && !host_push |=> !card_valid);

    assert_empty_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_index == REG_INDEX) |-> (reg_rdata[FLUSH_BIT] == !card_valid));

    assert_other_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_index != REG_INDEX) |-> (reg_rdata == '0));

    assert_sw_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sw_hit |=> !card_valid && !host_full);

    assert_scratch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en && (reg_index == REG_INDEX) |=>
            (reg_index != REG_INDEX) || reg_wr_en ||
            (reg_rdata[SCRATCH_W-1:0] == $past(reg_wdata[SCRATCH_W-1:0])));

    assert_pgood_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !power_good |=> !card_valid);

    assert_card_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !card_present |=> !card_valid);

    assert_vcc_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_en |=> !card_valid);

    assert_push_dropped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        host_push && any_flush |=> occupancy == '0);
endmodule

bind pw_fifo_socket pw_fifo_checker #(.DEPTH(DEPTH), .REG_INDEX(REG_INDEX)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_push    (host_push),
    .host_full    (host_full),
    .card_pop     (card_pop),
    .card_valid   (card_valid),
    .reg_index    (reg_index),
    .reg_wr_en    (reg_wr_en),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .power_good   (power_good),
    .card_present (card_present),
    .supply_en    (supply_en),
    .occupancy    (occupancy)
);

// File: tb/pw_fifo_socket_tb.sv
`timescale 1ns/1ps
module pw_fifo_socket_tb;
    import pw_fifo_pkg::*;

    localparam int         CLK_PERIOD = 10;
    localparam logic [7:0] IDX        = 8'h17;

    typedef struct packed {
        logic        push;
        logic        pop;
        logic [15:0] data;
        logic        exp_valid;
        logic [15:0] exp_head;
        logic        exp_full;
    } vec_t;

    localparam int NVEC = 21;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 16'h1111, 1'b1, 16'h1111, 1'b0},
        '{1'b1, 1'b0, 16'h2222, 1'b1, 16'h1111, 1'b0},
        '{1'b1, 1'b1, 16'h3333, 1'b1, 16'h2222, 1'b0},
        '{1'b1, 1'b0, 16'h4444, 1'b1, 16'h2222, 1'b0},
        '{1'b1, 1'b0, 16'h5555, 1'b1, 16'h2222, 1'b0},
        '{1'b1, 1'b0, 16'h6666, 1'b1, 16'h2222, 1'b0},
        '{1'b1, 1'b0, 16'h7777, 1'b1, 16'h2222, 1'b0},
        '{1'b1, 1'b0, 16'h8888, 1'b1, 16'h2222, 1'b0},
        '{1'b1, 1'b0, 16'h9999, 1'b1, 16'h2222, 1'b1},
        '{1'b1, 1'b0, 16'hAAAA, 1'b1, 16'h2222, 1'b1},
        '{1'b0, 1'b1, 16'h0000, 1'b1, 16'h3333, 1'b0},
        '{1'b1, 1'b1, 16'hBBBB, 1'b1, 16'h4444, 1'b0},
        '{1'b0, 1'b1, 16'h0000, 1'b1, 16'h5555, 1'b0},
        '{1'b0, 1'b1, 16'h0000, 1'b1, 16'h6666, 1'b0},
        '{1'b0, 1'b1, 16'h0000, 1'b1, 16'h7777, 1'b0},
        '{1'b0, 1'b1, 16'h0000, 1'b1, 16'h8888, 1'b0},
        '{1'b0, 1'b1, 16'h0000, 1'b1, 16'h9999, 1'b0},
        '{1'b0, 1'b1, 16'h0000, 1'b1, 16'hBBBB, 1'b0},
        '{1'b0, 1'b1, 16'h0000, 1'b0, 16'h0000, 1'b0},
        '{1'b0, 1'b1, 16'h0000, 1'b0, 16'h0000, 1'b0},
        '{1'b1, 1'b0, 16'hCCCC, 1'b1, 16'hCCCC, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_push = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [DATA_W-1:0] host_data = '0;
    logic [BE_W-1:0]   host_be = '0;
    logic              host_full;
    logic              card_pop = 1'b0;
    logic              card_valid;
    logic [ADDR_W-1:0] card_addr;
    logic [DATA_W-1:0] card_data;
    logic [BE_W-1:0]   card_be;
    logic [IDX_W-1:0]  reg_index = IDX;
    logic              reg_wr_en = 1'b0;
    logic [REG_W-1:0]  reg_wdata = '0;
    logic [REG_W-1:0]  reg_rdata;
    logic              power_good = 1'b1;
    logic              card_present = 1'b1;
    logic              supply_en = 1'b1;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pw_fifo_socket u_dut (
        .clk, .rst_n, .host_push, .host_addr, .host_data, .host_be, .host_full,
        .card_pop, .card_valid, .card_addr, .card_data, .card_be,
        .reg_index, .reg_wr_en, .reg_wdata, .reg_rdata,
        .power_good, .card_present, .supply_en
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        #1;
    endtask

    task automatic set_push(input logic [15:0] d);
        host_push = 1'b1;
        host_data = d;
        host_addr = d[11:0];
        host_be   = d[15:14];
    endtask

    task automatic push_one(input logic [15:0] d);
        set_push(d);
        cycle();
        host_push = 1'b0;
    endtask

    task automatic reg_write(input logic [7:0] idx, input logic [7:0] val);
        reg_index = idx;
        reg_wdata = val;
        reg_wr_en = 1'b1;
        cycle();
        reg_wr_en = 1'b0;
        reg_index = IDX;
    endtask

    task automatic reg_read(input logic [7:0] idx, output logic [7:0] val);
        reg_index = idx;
        #1;
        val = reg_rdata;
        reg_index = IDX;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] rv;

        // R1: reset state
        repeat (3) cycle();
        rst_n = 1'b1;
        cycle();
        reg_read(IDX, rv);
        chk("R1 reg", 32'(rv), 32'h80);
        chk("R1 full", 32'(host_full), 0);
        chk("R1 valid", 32'(card_valid), 0);

        // R2, R3, R4: table walk
        for (int i = 0; i < NVEC; i++) begin
            host_push = VECS[i].push;
            host_data = VECS[i].data;
            host_addr = VECS[i].data[11:0];
            host_be   = VECS[i].data[15:14];
            card_pop  = VECS[i].pop;
            cycle();
            host_push = 1'b0;
            card_pop  = 1'b0;
            chk("R2 valid", 32'(card_valid), 32'(VECS[i].exp_valid));
            chk("R3 full", 32'(host_full), 32'(VECS[i].exp_full));
            if (VECS[i].exp_valid) begin
                chk("R2 data", 32'(card_data), 32'(VECS[i].exp_head));
                chk("R2 addr", 32'(card_addr), 32'(VECS[i].exp_head[11:0]));
                chk("R2 be", 32'(card_be), 32'(VECS[i].exp_head[15:14]));
            end
        end

        // R5: status with data held, other index reads zero
        reg_read(IDX, rv);
        chk("R5 nonempty", 32'(rv), 32'h00);
        reg_read(8'h16, rv);
        chk("R5 other idx", 32'(rv), 32'h00);

        // R7: bit 7 clear keeps data, scratch stored
        reg_write(IDX, 8'h05);
        chk("R7 kept valid", 32'(card_valid), 1);
        chk("R7 kept head", 32'(card_data), 32'hCCCC);
        reg_read(IDX, rv);
        chk("R7 scratch", 32'(rv), 32'h05);

        // R12: other index write ignored
        reg_write(8'h16, 8'hFF);
        chk("R12 valid", 32'(card_valid), 1);
        reg_read(IDX, rv);
        chk("R12 scratch", 32'(rv), 32'h05);

        // R6: software flush
        reg_write(IDX, 8'h85);
        chk("R6 valid", 32'(card_valid), 0);
        reg_read(IDX, rv);
        chk("R6 reg", 32'(rv), 32'h85);

        // R4: pop on empty, then push lands as head
        card_pop = 1'b1;
        cycle();
        card_pop = 1'b0;
        chk("R4 empty pop", 32'(card_valid), 0);
        push_one(16'h1234);
        chk("R4 after pop", 32'(card_data), 32'h1234);

        // R8: power-good low with push in the same cycle
        push_one(16'h2345);
        power_good = 1'b0;
        set_push(16'h3456);
        cycle();
        chk("R8 valid", 32'(card_valid), 0);
        cycle();
        host_push = 1'b0;
        chk("R8 held", 32'(card_valid), 0);
        power_good = 1'b1;

        // R9: card removal
        push_one(16'h4567);
        push_one(16'h5678);
        card_present = 1'b0;
        cycle();
        chk("R9 valid", 32'(card_valid), 0);
        card_present = 1'b1;

        // R10: supply off
        push_one(16'h6789);
        push_one(16'h789A);
        supply_en = 1'b0;
        cycle();
        chk("R10 valid", 32'(card_valid), 0);
        chk("R10 full", 32'(host_full), 0);
        supply_en = 1'b1;

        // R11: full buffer, push and software flush together
        for (int k = 0; k < 8; k++) push_one(16'h0100 + 16'(k));
        chk("R3 full", 32'(host_full), 1);
        set_push(16'hFFFF);
        reg_write(IDX, 8'h80);
        host_push = 1'b0;
        chk("R11 valid", 32'(card_valid), 0);
        chk("R11 full", 32'(host_full), 0);
        reg_read(IDX, rv);
        chk("R11 reg", 32'(rv), 32'h80);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule